// File: doc/BRIEF.md
# Direction-Switched Shared Byte FIFO

This block holds one byte FIFO that is shared between a host bus port and a serial engine. Which side fills the FIFO and which side drains it is chosen at run time from a 2-bit mode field and a loopback control. In transmit configuration the host fills the FIFO and the engine drains it. In receive configuration the engine fills it and the host drains it. In loopback the engine both fills and drains it.

Strobes from the side that is not currently routed are ignored. The one exception is a host write that is not permitted: it is dropped and raises a sticky access-error flag. The most recently popped byte appears on both read-data outputs, so the host can always read the FIFO data whatever the routing. Changing the mode or loopback inputs never clears the stored bytes; it only redirects later accesses.

Top module: `dir_fifo_router`

## Requirements
- R1: The FIFO holds `DEPTH` (default 128) bytes. `count_o` reports occupancy from 0 to `DEPTH`. `full_o` is high exactly when the count equals `DEPTH`, and `empty_o` is high exactly when the count is 0.
- R2: Transmit is selected when `mode_i[1]` is 0. With `loop_i` low and transmit selected, `host_wr_i` pushes `host_wdata_i` and `eng_tx_rd_i` pops. `eng_rx_wr_i` then has no effect on the count.
- R3: With `loop_i` low and `mode_i[1]` equal to 1, `eng_rx_wr_i` pushes `eng_rx_data_i` and `host_rd_i` pops, in first-in first-out order.
- R4: With `loop_i` high, `mode_i` is ignored: `eng_rx_wr_i` pushes and `eng_tx_rd_i` pops. A host write then changes nothing in the FIFO.
- R5: A host write while loopback is high or receive is selected leaves the FIFO unchanged. It sets `acc_err_o` from the next cycle on. `acc_err_o` stays set until a cycle with `err_clr_i` high and no new rejected write.
- R6: `host_rdata_o` and `eng_tx_data_o` both show the last popped byte in every mode. They stay 0 until the first pop. A `host_rd_i` strobe outside receive configuration pops nothing.
- R7: A push and a pop in the same cycle, including while full, leave the count unchanged and lose no data.
- R8: A push to a full FIFO with no pop in the same cycle is dropped, and `overrun_o` pulses high in the next cycle.
- R9: A pop from an empty FIFO leaves the read data unchanged, and `underrun_o` pulses high in the next cycle.
- R10: A cycle with `flush_i` high empties the FIFO (count 0) and ignores that cycle's pushes and pops.
- R11: Changing `mode_i` or `loop_i` keeps the stored bytes and their order.
- R12: After reset the count is 0, `empty_o` is 1, and `full_o`, `acc_err_o`, `overrun_o`, `underrun_o` and the read data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode field; bit 1 low selects transmit |
| loop_i | input | 1 | Loopback: the engine both fills and drains |
| flush_i | input | 1 | Synchronous FIFO empty |
| err_clr_i | input | 1 | Clears the access-error flag |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write data |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 8 | Last popped byte, host side |
| eng_rx_wr_i | input | 1 | Engine receive write strobe |
| eng_rx_data_i | input | 8 | Engine receive data |
| eng_tx_rd_i | input | 1 | Engine transmit read strobe |
| eng_tx_data_o | output | 8 | Last popped byte, engine side |
| full_o | output | 1 | FIFO full |
| empty_o | output | 1 | FIFO empty |
| count_o | output | 8 | Occupancy |
| overrun_o | output | 1 | Pulse: a push was dropped |
| underrun_o | output | 1 | Pulse: a pop hit an empty FIFO |
| acc_err_o | output | 1 | Sticky rejected-host-write flag |

## Verification
The properties assume that `mode_i` and `loop_i` are stable at the clock edge and that every strobe is a clean level sampled once per edge. The stimulus drives all inputs at the falling edge and holds each strobe for exactly one rising edge. The hold-count and drop properties also assume that `flush_i` is low in the cycles they cover. The bench therefore asserts flush only in a dedicated cycle with no other strobes. Mode changes are made only between accesses, never while a strobe is high.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
   typedef enum logic [0:0] {
      SIDE_HOST   = 1'b0,
      SIDE_ENGINE = 1'b1
   } side_e;
endpackage

// File: rtl/dfr_route.sv
module dfr_route
   import dfr_pkg::*;
#(
   parameter int MODE_W = 2
) (
   input  logic [MODE_W-1:0] mode_i,
   input  logic              loop_i,
   output side_e             fill_side_o,
   output side_e             drain_side_o,
   output logic              host_wr_ok_o
);
   localparam int DIR_BIT = MODE_W - 1;

   initial assert (MODE_W >= 1) else $error("dfr_route: MODE_W must be at least 1");

   logic tx_sel;

   // Transmit is selected when the top bit of the mode field is clear.
   assign tx_sel = ~mode_i[DIR_BIT];

   always_comb begin
      if (loop_i) begin
         fill_side_o  = SIDE_ENGINE;
         drain_side_o = SIDE_ENGINE;
      end else if (tx_sel) begin
         fill_side_o  = SIDE_HOST;
         drain_side_o = SIDE_ENGINE;
      end else begin
         fill_side_o  = SIDE_ENGINE;
         drain_side_o = SIDE_HOST;
      end
   end

   assign host_wr_ok_o = ~loop_i & tx_sel;

   // R2 / R3: the host never both fills and drains the FIFO.
   always_comb begin
      p_host_single_role_r2: assert (!(fill_side_o == SIDE_HOST && drain_side_o == SIDE_HOST))
         else $error("host selected as both fill and drain");
   end
endmodule

// File: rtl/dfr_store.sv
module dfr_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 128
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush_i,
   input  logic          wr_req_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          rd_req_i,
   output logic [DW-1:0] rd_data_o,
   output logic [$clog2(DEPTH+1)-1:0] count_o,
   output logic          full_o,
   output logic          empty_o,
   output logic          overrun_o,
   output logic          underrun_o
);
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW   = $clog2(DEPTH + 1);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   initial assert (DEPTH >= 2) else $error("dfr_store: DEPTH must be at least 2");
   initial assert (DW >= 1) else $error("dfr_store: DW must be at least 1");

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt;
   logic [DW-1:0] rd_q;
   logic          push_ok, pop_ok;

   assign full_o  = (cnt == CW'(DEPTH));
   assign empty_o = (cnt == '0);
   assign pop_ok  = rd_req_i & ~empty_o;
   assign push_ok = wr_req_i & (~full_o | pop_ok);

   generate
      if (POW2) begin : g_wrap_nat
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok && !flush_i) mem[wr_ptr] <= wr_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr     <= '0;
         rd_ptr     <= '0;
         cnt        <= '0;
         rd_q       <= '0;
         overrun_o  <= 1'b0;
         underrun_o <= 1'b0;
      end else if (flush_i) begin
         wr_ptr     <= '0;
         rd_ptr     <= '0;
         cnt        <= '0;
         overrun_o  <= 1'b0;
         underrun_o <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok) begin
            rd_ptr <= rd_nxt;
            rd_q   <= mem[rd_ptr];
         end
         if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
         else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
         overrun_o  <= wr_req_i & ~push_ok;
         underrun_o <= rd_req_i & empty_o;
      end
   end

   assign rd_data_o = rd_q;
   assign count_o   = cnt;

   p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH)) else $error("count above depth");

   p_both_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_i && rd_req_i && !empty_o && !flush_i) |=> $stable(cnt))
      else $error("simultaneous push and pop moved the count");

   p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && wr_req_i && !rd_req_i && !flush_i) |=> (overrun_o && full_o))
      else $error("push to full not flagged");

   p_empty_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && rd_req_i && !flush_i) |=> (underrun_o && $stable(rd_q)))
      else $error("pop from empty changed data or not flagged");

   p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (empty_o && !overrun_o && !underrun_o))
      else $error("flush did not empty the FIFO");
endmodule

// File: rtl/dir_fifo_router.sv
module dir_fifo_router
   import dfr_pkg::*;
#(
   parameter int DW     = 8,
   parameter int DEPTH  = 128,
   parameter int MODE_W = 2,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              loop_i,
   input  logic              flush_i,
   input  logic              err_clr_i,
   input  logic              host_wr_i,
   input  logic [DW-1:0]     host_wdata_i,
   input  logic              host_rd_i,
   output logic [DW-1:0]     host_rdata_o,
   input  logic              eng_rx_wr_i,
   input  logic [DW-1:0]     eng_rx_data_i,
   input  logic              eng_tx_rd_i,
   output logic [DW-1:0]     eng_tx_data_o,
   output logic              full_o,
   output logic              empty_o,
   output logic [CW-1:0]     count_o,
   output logic              overrun_o,
   output logic              underrun_o,
   output logic              acc_err_o
);
   side_e         fill_side, drain_side;
   logic          host_wr_ok;
   logic          wr_req, rd_req;
   logic [DW-1:0] wr_data, rd_data;

   dfr_route #(.MODE_W(MODE_W)) u_route (
      .mode_i       (mode_i),
      .loop_i       (loop_i),
      .fill_side_o  (fill_side),
      .drain_side_o (drain_side),
      .host_wr_ok_o (host_wr_ok)
   );

   always_comb begin
      if (fill_side == SIDE_HOST) begin
         wr_req  = host_wr_i;
         wr_data = host_wdata_i;
      end else begin
         wr_req  = eng_rx_wr_i;
         wr_data = eng_rx_data_i;
      end
      rd_req = (drain_side == SIDE_HOST) ? host_rd_i : eng_tx_rd_i;
   end

   dfr_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush_i),
      .wr_req_i   (wr_req),
      .wr_data_i  (wr_data),
      .rd_req_i   (rd_req),
      .rd_data_o  (rd_data),
      .count_o    (count_o),
      .full_o     (full_o),
      .empty_o    (empty_o),
      .overrun_o  (overrun_o),
      .underrun_o (underrun_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       acc_err_o <= 1'b0;
      else if (host_wr_i && !host_wr_ok) acc_err_o <= 1'b1;
      else if (err_clr_i)               acc_err_o <= 1'b0;
   end

   assign host_rdata_o  = rd_data;
   assign eng_tx_data_o = rd_data;

   p_reject_sets_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_i && (loop_i || mode_i[MODE_W-1])) |=> acc_err_o)
      else $error("rejected host write did not raise the error flag");

   p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_err_o && !err_clr_i) |=> acc_err_o)
      else $error("error flag dropped without clear");

   p_loop_blocks_host_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_i && host_wr_i && !eng_rx_wr_i && !eng_tx_rd_i && !flush_i) |=> $stable(count_o))
      else $error("host write changed FIFO in loopback");

   p_full_empty_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_o && empty_o)) else $error("full and empty together");
endmodule

// File: tb/sim_dir_fifo_router.sv
module sim_dir_fifo_router;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 128;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] mode_i;
   logic       loop_i, flush_i, err_clr_i;
   logic       host_wr_i, host_rd_i, eng_rx_wr_i, eng_tx_rd_i;
   logic [7:0] host_wdata_i, eng_rx_data_i, host_rdata_o, eng_tx_data_o;
   logic       full_o, empty_o, overrun_o, underrun_o, acc_err_o;
   logic [7:0] count_o;

   int tests = 0;
   int fails = 0;
   logic [7:0] exp_q[$];
   logic [7:0] last_pop = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   dir_fifo_router u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .loop_i(loop_i),
      .flush_i(flush_i), .err_clr_i(err_clr_i),
      .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i),
      .host_rd_i(host_rd_i), .host_rdata_o(host_rdata_o),
      .eng_rx_wr_i(eng_rx_wr_i), .eng_rx_data_i(eng_rx_data_i),
      .eng_tx_rd_i(eng_tx_rd_i), .eng_tx_data_o(eng_tx_data_o),
      .full_o(full_o), .empty_o(empty_o), .count_o(count_o),
      .overrun_o(overrun_o), .underrun_o(underrun_o), .acc_err_o(acc_err_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic host_push(input logic [7:0] d);
      host_wr_i = 1'b1; host_wdata_i = d;
      tick();
      host_wr_i = 1'b0;
      exp_q.push_back(d);
   endtask

   task automatic eng_push(input logic [7:0] d);
      eng_rx_wr_i = 1'b1; eng_rx_data_i = d;
      tick();
      eng_rx_wr_i = 1'b0;
      exp_q.push_back(d);
   endtask

   // Monitor side of the scoreboard: pop, then compare with the queue head.
   task automatic pop_check(input string req, input bit by_host);
      logic [7:0] e;
      if (by_host) host_rd_i = 1'b1; else eng_tx_rd_i = 1'b1;
      tick();
      host_rd_i = 1'b0; eng_tx_rd_i = 1'b0;
      e = exp_q.pop_front();
      last_pop = e;
      chk(req, by_host ? host_rdata_o : eng_tx_data_o, e);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; mode_i = 2'b00; loop_i = 1'b0; flush_i = 1'b0; err_clr_i = 1'b0;
      host_wr_i = 1'b0; host_rd_i = 1'b0; eng_rx_wr_i = 1'b0; eng_tx_rd_i = 1'b0;
      host_wdata_i = '0; eng_rx_data_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk("R12 count", count_o, 0);
      chk("R12 flags", {empty_o, full_o, acc_err_o, overrun_o, underrun_o}, 5'b10000);
      chk("R12 rdata", host_rdata_o, 8'h00);

      // R2 transmit: host fills, engine drains
      mode_i = 2'b01;
      host_push(8'hA1); host_push(8'hA2); host_push(8'hA3);
      chk("R2 count after host pushes", count_o, 3);
      eng_rx_wr_i = 1'b1; eng_rx_data_i = 8'h55; tick(); eng_rx_wr_i = 1'b0;
      chk("R2 engine write ignored", count_o, 3);
      pop_check("R2 engine drain", 1'b0);
      // R6 host strobe outside receive config does not pop; data visible
      host_rd_i = 1'b1; tick(); host_rd_i = 1'b0;
      chk("R6 no pop in transmit", count_o, 2);
      chk("R6 host sees last pop", host_rdata_o, last_pop);
      pop_check("R2 engine drain", 1'b0);
      pop_check("R2 engine drain", 1'b0);

      // R3 receive: engine fills, host drains
      mode_i = 2'b10;
      eng_push(8'hB1); eng_push(8'hB2);
      // R5 rejected host write
      host_wr_i = 1'b1; host_wdata_i = 8'hCC; tick(); host_wr_i = 1'b0;
      chk("R5 count unchanged", count_o, 2);
      chk("R5 error set", acc_err_o, 1);
      tick();
      chk("R5 error sticky", acc_err_o, 1);
      err_clr_i = 1'b1; tick(); err_clr_i = 1'b0;
      chk("R5 error cleared", acc_err_o, 0);
      pop_check("R3 host drain", 1'b1);
      pop_check("R3 host drain", 1'b1);

      // R4 loopback, mode ignored
      loop_i = 1'b1; mode_i = 2'b00;
      eng_push(8'hD1); eng_push(8'hD2);
      host_wr_i = 1'b1; host_wdata_i = 8'hEE; tick(); host_wr_i = 1'b0;
      chk("R4 host write blocked", count_o, 2);
      chk("R4 error raised", acc_err_o, 1);
      err_clr_i = 1'b1; tick(); err_clr_i = 1'b0;
      pop_check("R4 engine loop drain", 1'b0);
      pop_check("R4 engine loop drain", 1'b0);

      // R1 fill to capacity in transmit
      loop_i = 1'b0; mode_i = 2'b00;
      for (int i = 0; i < DEPTH; i++) host_push(8'(i * 3 + 1));
      chk("R1 count full", count_o, DEPTH);
      chk("R1 full/empty", {full_o, empty_o}, 2'b10);
      // R8 overrun
      host_wr_i = 1'b1; host_wdata_i = 8'h99; tick(); host_wr_i = 1'b0;
      chk("R8 overrun pulse", overrun_o, 1);
      chk("R8 count held", count_o, DEPTH);
      tick();
      chk("R8 pulse ends", overrun_o, 0);
      // R7 simultaneous push and pop at full
      host_wr_i = 1'b1; host_wdata_i = 8'h77; eng_tx_rd_i = 1'b1;
      tick();
      host_wr_i = 1'b0; eng_tx_rd_i = 1'b0;
      last_pop = exp_q.pop_front();
      exp_q.push_back(8'h77);
      chk("R7 data at full", eng_tx_data_o, last_pop);
      chk("R7 count held", count_o, DEPTH);
      // R11 switch to receive keeps contents
      mode_i = 2'b11;
      tick();
      chk("R11 count kept", count_o, DEPTH);
      chk("R6 rdata kept over mode change", host_rdata_o, last_pop);
      for (int i = 0; i < DEPTH; i++) pop_check("R11 order kept", 1'b1);
      chk("R1 empty again", {full_o, empty_o}, 2'b01);

      // R9 underrun
      host_rd_i = 1'b1; tick(); host_rd_i = 1'b0;
      chk("R9 underrun pulse", underrun_o, 1);
      chk("R9 data unchanged", host_rdata_o, last_pop);
      chk("R9 count zero", count_o, 0);

      // R10 flush
      eng_push(8'h11); eng_push(8'h22); eng_push(8'h33);
      flush_i = 1'b1; tick(); flush_i = 1'b0;
      exp_q.delete();
      chk("R10 count cleared", count_o, 0);
      chk("R10 empty", empty_o, 1);
      eng_push(8'h44);
      pop_check("R10 fresh after flush", 1'b1);

      finish_run();
   end
endmodule